// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits at the issue stage of a two-wide, in-order pipeline. It takes two adjacent, already decoded instructions, called the first and the second in program order, together with a little context about where they sit in the flow. It then decides whether the two may leave the issue stage in the same cycle. When they may not, it gives a reason code. Issue logic uses the decision to send the pair together or to send only the first instruction.

Each instruction arrives as a packed descriptor. The descriptor carries:
- an issue class;
- a destination register and two source registers, each with a valid bit;
- flags for floating point, doubleword access, store, carry write, carry read and may-nullify-successor.

Register numbers share one namespace, which the decoder prepares. Bit 0 of a number selects the half of a doubleword pair. Pairing follows an asymmetric table of first and second classes, plus several special refusals. The parameter `REGISTERED` (default 1) adds one flop stage on the outputs.

Top module: `dual_issue_pair_check`

## Requirements
- R1: `allowed_o` is 1 exactly when `reason_o` is 0. The refusal codes are: 1 system, 2 delay slot, 3 odd branch target, 4 class table, 5 nullify flag, 6 register dependency, 7 doubleword half, 8 same FP target, 9 carry.
- R2: With `REGISTERED`=1 the outputs show the verdict for the inputs present at the previous rising clock edge. While `rst_n` is low, a clock edge sets `allowed_o`=0 and `reason_o`=15.
- R3: If either instruction has class 8 (system control), the verdict is code 1.
- R4: If `dly_a_i` or `dly_b_i` is high (that instruction is in a branch delay slot), the verdict is code 2.
- R5: If `odd_tgt_a_i` is high (the first instruction is a taken-branch target at an odd word address), the verdict is code 3.
- R6: Classes are encoded as: 0 FP operation, 1 load/store, 2 integer ALU, 3 shift/extract/deposit, 4 nullifying, 5 indirect branch, 6 other branch, 7 FP status. The following pairs are refused with code 4:
  - every first class outside 0 to 4, including the undefined codes 9 to 15;
  - any second class that the first class does not allow.

  The allowed second classes are:
  - after 0: {1,2,3,4,5,6};
  - after 1: {0,2,3,4,6};
  - after 2: {0,1,2,3,4,6,7};
  - after 3: {0,1,2,7};
  - after 4: {0}.
- R7: If the first instruction has the may-nullify flag set and the second is not class 0, the verdict is code 5.
- R8: If the first instruction's valid destination matches a valid source of the second, the verdict is code 6. Registers match when the numbers are equal, or, if either instruction has the doubleword flag, when all bits above bit 0 are equal. One case is exempt: a class 0 first instruction followed by an FP store (class 1, FP and store flags set) is allowed when only source 1 (the store data) matches.
- R9: Consider an FP load (class 1, FP flag set, store flag clear, doubleword clear) that targets register r, paired in either order with a class 0 instruction. If any valid register of the class 0 instruction equals r with bit 0 inverted, the verdict is code 7.
- R10: A class 0 instruction and an FP load with equal valid destination numbers, in either order, give code 8.
- R11: If one instruction writes carry and the other reads carry, in either order, the verdict is code 9.
- R12: When several rules fail, the lowest code from 1 to 9 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_a_i | input | DESC_W (28) | First instruction descriptor (`desc_t` layout: class, dst, dst valid, src0, src0 valid, src1, src1 valid, fp, dw, store, carry write, carry read, may-nullify, most significant first) |
| insn_b_i | input | DESC_W (28) | Second instruction descriptor, same layout |
| dly_a_i | input | 1 | First instruction is in a branch delay slot |
| dly_b_i | input | 1 | Second instruction is in a branch delay slot |
| odd_tgt_a_i | input | 1 | First instruction is a taken-branch target at an odd word address |
| allowed_o | output | 1 | Pair may issue together |
| reason_o | output | 4 | Refusal code, 0 when allowed |

## Verification
Three kinds of stimulus are used:
- **Full class sweep.** All 256 first/second class codes are run with disjoint registers and no flags. This isolates the class table and the system rule from every hazard rule, so a single wrong table entry shows up.
- **Directed pairs.** Each special case is set up from both sides of its boundary:
  - store data against store base for the forwarding exemption;
  - equal halves against opposite halves for the doubleword rule;
  - both operand orders for the carry and FP-load rules.

  Stacked failures then show whether the priority order is respected.
- **Random descriptors.** These draw from a small register range so that overlaps are frequent, mixing rules in ways the directed cases do not.

// File: rtl/pair_pkg.sv
// Shared types and encodings for the dual-issue pairing checker.
// Assumes one unified register namespace prepared by the decoder; bit 0 of a
// register number selects the half of a doubleword pair.
package pair_pkg;
    parameter int REG_W = 5;

    localparam logic [3:0] CL_FLOP  = 4'd0;
    localparam logic [3:0] CL_LDST  = 4'd1;
    localparam logic [3:0] CL_ALU   = 4'd2;
    localparam logic [3:0] CL_SHIFT = 4'd3;
    localparam logic [3:0] CL_NUL   = 4'd4;
    localparam logic [3:0] CL_IBR   = 4'd5;
    localparam logic [3:0] CL_BR    = 4'd6;
    localparam logic [3:0] CL_FSTAT = 4'd7;
    localparam logic [3:0] CL_SYS   = 4'd8;

    localparam logic [3:0] RSN_OK    = 4'd0;
    localparam logic [3:0] RSN_SYS   = 4'd1;
    localparam logic [3:0] RSN_DLY   = 4'd2;
    localparam logic [3:0] RSN_ODD   = 4'd3;
    localparam logic [3:0] RSN_CLASS = 4'd4;
    localparam logic [3:0] RSN_NUL   = 4'd5;
    localparam logic [3:0] RSN_RAW   = 4'd6;
    localparam logic [3:0] RSN_HALF  = 4'd7;
    localparam logic [3:0] RSN_FPTGT = 4'd8;
    localparam logic [3:0] RSN_CARRY = 4'd9;
    localparam logic [3:0] RSN_IDLE  = 4'd15;

    typedef struct packed {
        logic [3:0]       cls;
        logic [REG_W-1:0] dst;
        logic             dst_v;
        logic [REG_W-1:0] src0;
        logic             src0_v;
        logic [REG_W-1:0] src1;
        logic             src1_v;
        logic             is_fp;
        logic             is_dw;
        logic             is_store;
        logic             carry_wr;
        logic             carry_rd;
        logic             may_nul;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/pair_class_table.sv
// Asymmetric first/second class compatibility table.
// Assumes class codes from pair_pkg; codes 9..15 are undefined and never pair.
module pair_class_table
    import pair_pkg::*;
(
    input  logic [3:0] cls_a_i,
    input  logic [3:0] cls_b_i,
    output logic       ok_o
);
    logic [15:0] mask;

    // Select the set of second classes permitted after the first class.
    always_comb begin
        mask = '0;
        case (cls_a_i)
            CL_FLOP: begin
                mask[CL_LDST]  = 1'b1;
                mask[CL_ALU]   = 1'b1;
                mask[CL_SHIFT] = 1'b1;
                mask[CL_NUL]   = 1'b1;
                mask[CL_IBR]   = 1'b1;
                mask[CL_BR]    = 1'b1;
            end
            CL_LDST: begin
                mask[CL_FLOP]  = 1'b1;
                mask[CL_ALU]   = 1'b1;
                mask[CL_SHIFT] = 1'b1;
                mask[CL_NUL]   = 1'b1;
                mask[CL_BR]    = 1'b1;
            end
            CL_ALU: begin
                mask[CL_FLOP]  = 1'b1;
                mask[CL_LDST]  = 1'b1;
                mask[CL_ALU]   = 1'b1;
                mask[CL_SHIFT] = 1'b1;
                mask[CL_NUL]   = 1'b1;
                mask[CL_BR]    = 1'b1;
                mask[CL_FSTAT] = 1'b1;
            end
            CL_SHIFT: begin
                mask[CL_FLOP]  = 1'b1;
                mask[CL_LDST]  = 1'b1;
                mask[CL_ALU]   = 1'b1;
                mask[CL_FSTAT] = 1'b1;
            end
            CL_NUL: begin
                mask[CL_FLOP]  = 1'b1;
            end
            default: mask = '0;
        endcase
    end

    assign ok_o = mask[cls_b_i];
endmodule

// File: rtl/pair_hazard_check.sv
// Operand and flag hazards between the first (a) and second (b) instruction:
// read-after-write with the FP-store data exemption, doubleword halves,
// FP-load/FP-operation equal targets and carry conflicts.
// Assumes the store data register is carried in source 1.
module pair_hazard_check
    import pair_pkg::*;
(
    input  desc_t ins_a_i,
    input  desc_t ins_b_i,
    output logic  raw_o,
    output logic  half_o,
    output logic  fptgt_o,
    output logic  carry_o
);
    localparam logic [REG_W-1:0] HALF_BIT = {{(REG_W-1){1'b0}}, 1'b1};

    // Register overlap; a doubleword operand covers both halves.
    function automatic logic reg_hit(logic [REG_W-1:0] r, logic [REG_W-1:0] s, logic wide);
        if (wide) return r[REG_W-1:1] == s[REG_W-1:1];
        return r == s;
    endfunction

    // Any valid register of an FP operation sitting on the other half of r.
    function automatic logic other_half(desc_t f, logic [REG_W-1:0] r);
        logic [REG_W-1:0] o;
        o = r ^ HALF_BIT;
        return (f.dst_v && f.dst == o) || (f.src0_v && f.src0 == o) ||
               (f.src1_v && f.src1 == o);
    endfunction

    logic [1:0][REG_W-1:0] b_src;
    logic [1:0]            b_src_v;
    logic [1:0]            src_hit;
    logic                  wide;
    logic                  a_flop, b_flop, a_fpld, b_fpld, b_fpst, fwd_ok;

    assign b_src   = {ins_b_i.src1, ins_b_i.src0};
    assign b_src_v = {ins_b_i.src1_v, ins_b_i.src0_v};
    assign wide    = ins_a_i.is_dw | ins_b_i.is_dw;

    // One dependency comparator per source operand of the second instruction.
    for (genvar i = 0; i < 2; i++) begin : g_src
        assign src_hit[i] = ins_a_i.dst_v & b_src_v[i] & reg_hit(ins_a_i.dst, b_src[i], wide);
    end

    assign a_flop = ins_a_i.cls == CL_FLOP;
    assign b_flop = ins_b_i.cls == CL_FLOP;
    assign a_fpld = ins_a_i.cls == CL_LDST && ins_a_i.is_fp && !ins_a_i.is_store;
    assign b_fpld = ins_b_i.cls == CL_LDST && ins_b_i.is_fp && !ins_b_i.is_store;
    assign b_fpst = ins_b_i.cls == CL_LDST && ins_b_i.is_fp && ins_b_i.is_store;
    assign fwd_ok = a_flop & b_fpst;

    // Combine the per-rule hazards.
    always_comb begin
        raw_o   = src_hit[0] | (src_hit[1] & ~fwd_ok);
        half_o  = (a_fpld && !ins_a_i.is_dw && ins_a_i.dst_v && b_flop &&
                   other_half(ins_b_i, ins_a_i.dst)) ||
                  (b_fpld && !ins_b_i.is_dw && ins_b_i.dst_v && a_flop &&
                   other_half(ins_a_i, ins_b_i.dst));
        fptgt_o = ((a_flop && b_fpld) || (a_fpld && b_flop)) &&
                  ins_a_i.dst_v && ins_b_i.dst_v && ins_a_i.dst == ins_b_i.dst;
        carry_o = (ins_a_i.carry_wr & ins_b_i.carry_rd) |
                  (ins_b_i.carry_wr & ins_a_i.carry_rd);
    end
endmodule

// File: rtl/dual_issue_pair_check.sv
// Top of the pairing checker: merges context, class and hazard rules into
// one verdict with a prioritised reason code, optionally registered.
// Assumes descriptors follow pair_pkg::desc_t; clk/rst_n serve only the
// output stage.
module dual_issue_pair_check
    import pair_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DESC_W-1:0] insn_a_i,
    input  logic [DESC_W-1:0] insn_b_i,
    input  logic              dly_a_i,
    input  logic              dly_b_i,
    input  logic              odd_tgt_a_i,
    output logic              allowed_o,
    output logic [3:0]        reason_o
);
    desc_t      ins_a, ins_b;
    logic       class_ok, raw, half, fptgt, carry;
    logic       sys_hit, dly_hit, nul_hit;
    logic       allowed_c;
    logic [3:0] reason_c;

    assign ins_a = desc_t'(insn_a_i);
    assign ins_b = desc_t'(insn_b_i);

    pair_class_table u_table (
        .cls_a_i (ins_a.cls),
        .cls_b_i (ins_b.cls),
        .ok_o    (class_ok)
    );

    pair_hazard_check u_hazard (
        .ins_a_i (ins_a),
        .ins_b_i (ins_b),
        .raw_o   (raw),
        .half_o  (half),
        .fptgt_o (fptgt),
        .carry_o (carry)
    );

    assign sys_hit = (ins_a.cls == CL_SYS) | (ins_b.cls == CL_SYS);
    assign dly_hit = dly_a_i | dly_b_i;
    assign nul_hit = ins_a.may_nul & (ins_b.cls != CL_FLOP);

    // Pick the highest-priority failing rule.
    always_comb begin
        if (sys_hit)          reason_c = RSN_SYS;
        else if (dly_hit)     reason_c = RSN_DLY;
        else if (odd_tgt_a_i) reason_c = RSN_ODD;
        else if (!class_ok)   reason_c = RSN_CLASS;
        else if (nul_hit)     reason_c = RSN_NUL;
        else if (raw)         reason_c = RSN_RAW;
        else if (half)        reason_c = RSN_HALF;
        else if (fptgt)       reason_c = RSN_FPTGT;
        else if (carry)       reason_c = RSN_CARRY;
        else                  reason_c = RSN_OK;
    end

    // Verdict bit built straight from the rules, not from the code.
    assign allowed_c = ~(sys_hit | dly_hit | odd_tgt_a_i | ~class_ok | nul_hit |
                         raw | half | fptgt | carry);

    if (REGISTERED) begin : g_reg
        logic       allowed_q;
        logic [3:0] reason_q;

        // Output stage; reset shows "refused, idle".
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                allowed_q <= 1'b0;
                reason_q  <= RSN_IDLE;
            end else begin
                allowed_q <= allowed_c;
                reason_q  <= reason_c;
            end
        end
        assign allowed_o = allowed_q;
        assign reason_o  = reason_q;
    end else begin : g_comb
        assign allowed_o = allowed_c;
        assign reason_o  = reason_c;
    end
endmodule

// File: rtl/dual_issue_pair_check_sva.sv
// Property checker for dual_issue_pair_check, attached by bind.
// Keeps its own copy of the inputs aligned with the output latency.
module dual_issue_pair_check_sva
    import pair_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DESC_W-1:0] insn_a_i,
    input logic [DESC_W-1:0] insn_b_i,
    input logic              dly_a_i,
    input logic              dly_b_i,
    input logic              odd_tgt_a_i,
    input logic              allowed_o,
    input logic [3:0]        reason_o
);
    desc_t qa, qb;
    logic  qdly, qodd, qv;

    if (REGISTERED) begin : g_align
        // Hold the inputs the outputs currently describe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                qa <= '0; qb <= '0; qdly <= 1'b0; qodd <= 1'b0; qv <= 1'b0;
            end else begin
                qa <= desc_t'(insn_a_i); qb <= desc_t'(insn_b_i);
                qdly <= dly_a_i | dly_b_i; qodd <= odd_tgt_a_i; qv <= 1'b1;
            end
        end
    end else begin : g_align
        assign qa = desc_t'(insn_a_i);
        assign qb = desc_t'(insn_b_i);
        assign qdly = dly_a_i | dly_b_i;
        assign qodd = odd_tgt_a_i;
        assign qv = 1'b1;
    end

    a_r1_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        qv |-> (allowed_o == (reason_o == RSN_OK)));

    a_r3_system_first: assert property (@(posedge clk) disable iff (!rst_n)
        (qv && (qa.cls == CL_SYS || qb.cls == CL_SYS)) |-> (reason_o == RSN_SYS));

    a_r4_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (qv && qdly && qa.cls != CL_SYS && qb.cls != CL_SYS) |-> (reason_o == RSN_DLY));

    a_r5_odd_target: assert property (@(posedge clk) disable iff (!rst_n)
        (qv && qodd) |-> !allowed_o);

    a_r7_nullify_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (qv && qa.may_nul && qb.cls != CL_FLOP) |-> !allowed_o);

    a_r11_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (qv && ((qa.carry_wr && qb.carry_rd) || (qb.carry_wr && qa.carry_rd))) |-> !allowed_o);
endmodule

bind dual_issue_pair_check dual_issue_pair_check_sva #(.REGISTERED(REGISTERED)) u_sva (.*);

// File: tb/tb_dual_issue_pair_check.sv
// Self-checking bench: full class sweep, directed rule cases, seeded random.
module tb_dual_issue_pair_check;
    import pair_pkg::*;

    localparam time CLK_P = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DESC_W-1:0] insn_a_i = '0, insn_b_i = '0;
    logic              dly_a_i = 1'b0, dly_b_i = 1'b0, odd_tgt_a_i = 1'b0;
    logic              allowed_o;
    logic [3:0]        reason_o;
    int                checks = 0, errors = 0;
    bit                done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_issue_pair_check dut (.*);

    // Which second classes a first class accepts (R6).
    function automatic bit table_ok(logic [3:0] f, logic [3:0] s);
        case (f)
            4'd0: return s inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
            4'd1: return s inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd6};
            4'd2: return s inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7};
            4'd3: return s inside {4'd0, 4'd1, 4'd2, 4'd7};
            4'd4: return s == 4'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit match(logic [REG_W-1:0] x, logic [REG_W-1:0] y, bit dw);
        return dw ? (x >> 1) == (y >> 1) : x == y;
    endfunction

    function automatic bit is_fpld(desc_t d);
        return d.cls == 4'd1 && d.is_fp && !d.is_store;
    endfunction

    function automatic bit opp_half(desc_t f, logic [REG_W-1:0] r);
        logic [REG_W-1:0] o;
        o = {r[REG_W-1:1], ~r[0]};
        return (f.dst_v && f.dst == o) || (f.src0_v && f.src0 == o) || (f.src1_v && f.src1 == o);
    endfunction

    // Reference verdict built from R3..R12.
    function automatic logic [3:0] ref_reason(desc_t a, desc_t b, bit da, bit db, bit od);
        bit dw, h0, h1, st;
        dw = a.is_dw || b.is_dw;
        h0 = a.dst_v && b.src0_v && match(a.dst, b.src0, dw);
        h1 = a.dst_v && b.src1_v && match(a.dst, b.src1, dw);
        st = a.cls == 4'd0 && b.cls == 4'd1 && b.is_fp && b.is_store;
        if (a.cls == 4'd8 || b.cls == 4'd8) return 4'd1;
        if (da || db) return 4'd2;
        if (od) return 4'd3;
        if (!table_ok(a.cls, b.cls)) return 4'd4;
        if (a.may_nul && b.cls != 4'd0) return 4'd5;
        if (h0 || (h1 && !st)) return 4'd6;
        if ((is_fpld(a) && !a.is_dw && a.dst_v && b.cls == 4'd0 && opp_half(b, a.dst)) ||
            (is_fpld(b) && !b.is_dw && b.dst_v && a.cls == 4'd0 && opp_half(a, b.dst)))
            return 4'd7;
        if (((a.cls == 4'd0 && is_fpld(b)) || (is_fpld(a) && b.cls == 4'd0)) &&
            a.dst_v && b.dst_v && a.dst == b.dst) return 4'd8;
        if ((a.carry_wr && b.carry_rd) || (b.carry_wr && a.carry_rd)) return 4'd9;
        return 4'd0;
    endfunction

    function automatic desc_t mk(logic [3:0] c, int d, int s0, int s1);
        desc_t x;
        x = '0;
        x.cls = c;
        if (d >= 0)  begin x.dst  = REG_W'(d);  x.dst_v  = 1'b1; end
        if (s0 >= 0) begin x.src0 = REG_W'(s0); x.src0_v = 1'b1; end
        if (s1 >= 0) begin x.src1 = REG_W'(s1); x.src1_v = 1'b1; end
        return x;
    endfunction

    task automatic check(string tag, logic [3:0] exp_r);
        checks++;
        if (reason_o !== exp_r || allowed_o !== (exp_r == 4'd0)) begin
            errors++;
            $display("FAIL %s reason=%0d allowed=%0b expected reason=%0d allowed=%0b",
                     tag, reason_o, allowed_o, exp_r, exp_r == 4'd0);
        end
    endtask

    // Drive a pair, let one edge register it, check at the following negedge.
    task automatic run(string tag, desc_t a, desc_t b, bit da, bit db, bit od);
        @(negedge clk);
        insn_a_i = a; insn_b_i = b; dly_a_i = da; dly_b_i = db; odd_tgt_a_i = od;
        @(negedge clk);
        check(tag, ref_reason(a, b, da, db, od));
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        desc_t a, b;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        check("R2 reset idle", 4'd15);
        rst_n = 1'b1;

        // R6 and R3: every class pair with disjoint operands and no flags.
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run((i == 8 || j == 8) ? "R3 sweep" : "R6 sweep",
                    mk(4'(i), 1, -1, -1), mk(4'(j), 9, 2, 3), 0, 0, 0);

        // R2: output holds until the next edge, then follows.
        run("R2 clean", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 6, 7), 0, 0, 0);
        @(negedge clk);
        insn_b_i = mk(CL_ALU, 5, 4, 7);
        #1 check("R2 before edge", 4'd0);
        @(negedge clk);
        check("R2 after edge", 4'd6);

        run("R4 second in slot", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 6, -1), 0, 1, 0);
        run("R4 first in slot", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 6, -1), 1, 0, 0);
        run("R5 odd target", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 6, -1), 0, 0, 1);

        a = mk(CL_ALU, 4, -1, -1); a.may_nul = 1'b1;
        run("R7 nullify alu", a, mk(CL_ALU, 5, 6, -1), 0, 0, 0);
        run("R7 nullify flop ok", a, mk(CL_FLOP, 5, 6, -1), 0, 0, 0);

        run("R8 raw src0", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 4, -1), 0, 0, 0);
        b = mk(CL_LDST, -1, 2, 6); b.is_fp = 1'b1; b.is_store = 1'b1;
        run("R8 fp store forward ok", mk(CL_FLOP, 6, 1, -1), b, 0, 0, 0);
        b.src0 = 5'd6;
        run("R8 store base dep", mk(CL_FLOP, 6, 1, -1), b, 0, 0, 0);
        b.src0 = 5'd2; b.is_fp = 1'b0;
        run("R8 int store dep", mk(CL_FLOP, 6, 1, -1), b, 0, 0, 0);
        a = mk(CL_FLOP, 6, -1, -1); a.is_dw = 1'b1;
        run("R8 doubleword dep", a, mk(CL_ALU, 9, 7, -1), 0, 0, 0);

        a = mk(CL_LDST, 4, 1, -1); a.is_fp = 1'b1;
        run("R9 half load then flop", a, mk(CL_FLOP, 10, 5, -1), 0, 0, 0);
        run("R12 raw over half", a, mk(CL_FLOP, 10, 4, 5), 0, 0, 0);
        run("R9 flop then half load", mk(CL_FLOP, 10, 5, -1), a, 0, 0, 0);

        b = mk(CL_LDST, 8, 1, -1); b.is_fp = 1'b1;
        run("R10 same target", mk(CL_FLOP, 8, 2, 3), b, 0, 0, 0);

        a = mk(CL_ALU, 4, -1, -1); a.carry_wr = 1'b1;
        b = mk(CL_ALU, 5, 6, -1);  b.carry_rd = 1'b1;
        run("R11 carry write then read", a, b, 0, 0, 0);
        run("R11 carry read then write", b, a, 0, 0, 0);

        run("R12 sys over slot", mk(CL_SYS, 4, -1, -1), mk(CL_ALU, 5, 6, -1), 1, 0, 0);
        run("R12 slot over odd", mk(CL_ALU, 4, -1, -1), mk(CL_ALU, 5, 6, -1), 0, 1, 1);
        run("R12 odd over class", mk(CL_SHIFT, 4, -1, -1), mk(CL_SHIFT, 5, 6, -1), 0, 0, 1);
        run("R12 class over raw", mk(CL_SHIFT, 4, -1, -1), mk(CL_SHIFT, 5, 4, -1), 0, 0, 0);

        // R1 and mixed rules under seeded random descriptors.
        for (int n = 0; n < 3000; n++) begin
            desc_t ra, rb;
            ra = desc_t'({$urandom, $urandom});
            rb = desc_t'({$urandom, $urandom});
            ra.cls = 4'($urandom % 10); rb.cls = 4'($urandom % 10);
            ra.dst = ra.dst & 5'd7; ra.src0 = ra.src0 & 5'd7; ra.src1 = ra.src1 & 5'd7;
            rb.dst = rb.dst & 5'd7; rb.src0 = rb.src0 & 5'd7; rb.src1 = rb.src1 & 5'd7;
            run("R1 random", ra, rb, ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule